// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer/Counter

This block is an 8-bit up-counter that advances on a prescaled tick. A mode input puts it into one of three roles. As an interval timer, it restarts each time the count reaches a reference value and toggles a square-wave output. As a pulse-width modulator, it runs freely through all 256 counts and drives a pulse whose high time equals the reference. As an input-capture unit, it stores the count at the moment a chosen edge arrives on an external pin. In capture mode it also reports each wrap of the counter.

One data register serves two purposes. The CPU writes the reference value into it, and in capture mode the hardware overwrites it with the captured count. The register can always be read. Two pending flags report events to an interrupt controller: one for overflow and one for match or capture. Each flag has its own acknowledge strobe, which the controller pulses when it services that interrupt.

Top module: `multimode_timer`

## Requirements
- R1: After reset, the toggle output, the PWM output, both pending flags and the data register are all 0. The internal count is 00H.
- R2: The mode input selects the behaviour: 0 is interval, 1 is PWM, 2 is capture and 3 is idle. In interval mode, a tick that finds the count equal to the data register clears the count to 00H, flips `tgl_out` and sets `mc_pend`. With reference D, the toggle therefore flips on the (D+1)-th tick after the counter is cleared.
- R3: In PWM mode, a reference match does not clear the counter, and the counter wraps from FFH to 00H. `pwm_out` is 1 exactly while the data register is greater than the count, and 0 otherwise. Over 256 ticks it is high for D ticks. `pwm_out` is 0 in every other mode.
- R4: In capture mode, `cap_pin` passes through a two-flop synchroniser before edge detection. `cap_rise`=1 selects rising edges and 0 selects falling edges, and the other edge is ignored. With ticks running, the data register takes the count three clocks after the pin changes, and `mc_pend` is set on the same edge. Each detected edge is captured once.
- R5: In capture mode only, a tick that finds the count at FFH wraps the counter and sets `ovf_pend`.
- R6: An acknowledge clears its flag on the next clock. If a set event and an acknowledge for the same flag fall in the same cycle, the flag stays set.
- R7: The counter and the match, overflow and capture events advance only in cycles where `tick_en` is 1. Edge detection on `cap_pin` runs on every clock.
- R8: A CPU write loads the data register on the next clock. If a write and a capture load fall on the same clock, the capture load wins.
- R9: A change of the mode input, or `cnt_clr`=1, clears the count to 00H on the next clock. It leaves both flags unchanged and blocks all events in that cycle.
- R10: In idle mode (3), the counter holds its value and no event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Prescaled count enable |
| mode_sel | input | 2 | Mode: 0 interval, 1 PWM, 2 capture, 3 idle |
| cnt_clr | input | 1 | Clear the counter |
| cap_rise | input | 1 | Capture edge: 1 rising, 0 falling |
| cap_pin | input | 1 | Asynchronous capture input |
| wr_en | input | 1 | CPU write strobe for the data register |
| wr_data | input | 8 | CPU write value |
| ack_ovf | input | 1 | Acknowledge for the overflow flag |
| ack_mc | input | 1 | Acknowledge for the match/capture flag |
| tgl_out | output | 1 | Interval toggle output |
| pwm_out | output | 1 | PWM output |
| data_q | output | 8 | Data register: reference or captured count |
| ovf_pend | output | 1 | Overflow pending flag |
| mc_pend | output | 1 | Match/capture pending flag |

## Verification
The internal count is not visible at the ports, but every error in it appears in the outputs. A wrong count or clear shifts the interval toggle period by a whole number of ticks, and moves the PWM high-to-low transition within one 256-tick period. It also changes the captured value by the same offset at the very next edge. A synchroniser that is too short or too long moves the capture by one clock, and a wrong polarity captures on the wrong edge. Both show in the data register and in `mc_pend` three clocks after the pin changes. A wrong flag priority shows one clock after the collision cycle.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
   typedef enum logic [1:0] {
      MMT_INTERVAL = 2'd0,
      MMT_PWM      = 2'd1,
      MMT_CAPTURE  = 2'd2,
      MMT_IDLE     = 2'd3
   } mmt_mode_e;

   localparam int MMT_NFLAGS = 2;
   localparam int MMT_F_OVF  = 0;
   localparam int MMT_F_MC   = 1;
endpackage

// File: rtl/mmt_edge_sync.sv
module mmt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic rise_i,
   output logic edge_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;
   logic              synced;

   generate
      if (STAGES < 2) begin : g_bad
         $error("mmt_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   assign synced = chain_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         last_q  <= synced;
      end
   end

   assign edge_o = rise_i ? (synced & ~last_q) : (~synced & last_q);
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic             match_clr_i,
   input  logic [CNT_W-1:0] ref_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o,
   output logic             top_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             live;

   assign live  = tick_i & run_i & ~clr_i;
   assign hit_o = live & (cnt_q == ref_i);
   assign top_o = live & (cnt_q == CNT_TOP);
   assign cnt_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clr_i)              cnt_q <= '0;
      else if (live) begin
         if (match_clr_i && hit_o) cnt_q <= '0;
         else                      cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mmt_pend_flag.sv
module mmt_pend_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ack_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= set_i | (q_o & ~ack_i);
   end
endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
   import mmt_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [1:0]       mode_sel,
   input  logic             cnt_clr,
   input  logic             cap_rise,
   input  logic             cap_pin,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             ack_ovf,
   input  logic             ack_mc,
   output logic             tgl_out,
   output logic             pwm_out,
   output logic [CNT_W-1:0] data_q,
   output logic             ovf_pend,
   output logic             mc_pend
);
   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("multimode_timer: CNT_W must be at least 2");
      end
   endgenerate

   mmt_mode_e        mode_q;
   logic             mode_chg;
   logic             clr_any;
   logic [CNT_W-1:0] cnt;
   logic             hit, top;
   logic             edge_now;
   logic             cap_wait_q;
   logic             cap_fire;
   logic             match_evt;
   logic             ovf_evt;
   logic             mc_set;
   logic [MMT_NFLAGS-1:0] flag_set, flag_ack, flag_q;

   assign mode_chg = (mode_sel != mode_q);
   assign clr_any  = cnt_clr | mode_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MMT_INTERVAL;
      else        mode_q <= mmt_mode_e'(mode_sel);
   end

   mmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_en),
      .clr_i       (clr_any),
      .run_i       (mode_q != MMT_IDLE),
      .match_clr_i (mode_q == MMT_INTERVAL),
      .ref_i       (data_q),
      .cnt_o       (cnt),
      .hit_o       (hit),
      .top_o       (top)
   );

   mmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (cap_pin),
      .rise_i (cap_rise),
      .edge_o (edge_now)
   );

   // an edge seen between ticks waits for the next tick; one load per edge
   assign cap_fire = (mode_q == MMT_CAPTURE) & tick_en & ~clr_any & (cap_wait_q | edge_now);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cap_wait_q <= 1'b0;
      else if (mode_q != MMT_CAPTURE) cap_wait_q <= 1'b0;
      else                           cap_wait_q <= (cap_wait_q | edge_now) & ~cap_fire;
   end

   assign match_evt = hit & (mode_q == MMT_INTERVAL);
   assign ovf_evt   = top & (mode_q == MMT_CAPTURE);
   assign mc_set    = match_evt | cap_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         data_q <= '0;
      else if (cap_fire)  data_q <= cnt;
      else if (wr_en)     data_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tgl_out <= 1'b0;
      else if (match_evt) tgl_out <= ~tgl_out;
   end

   assign pwm_out = (mode_q == MMT_PWM) & (data_q > cnt);

   assign flag_set[MMT_F_OVF] = ovf_evt;
   assign flag_set[MMT_F_MC]  = mc_set;
   assign flag_ack[MMT_F_OVF] = ack_ovf;
   assign flag_ack[MMT_F_MC]  = ack_mc;

   generate
      for (genvar g = 0; g < MMT_NFLAGS; g++) begin : g_flag
         mmt_pend_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_set[g]),
            .ack_i (flag_ack[g]),
            .q_o   (flag_q[g])
         );
      end
   endgenerate

   assign ovf_pend = flag_q[MMT_F_OVF];
   assign mc_pend  = flag_q[MMT_F_MC];
endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             cnt_clr,
   input logic [1:0]       mode_sel,
   input logic [1:0]       mode_q,
   input logic             ack_ovf,
   input logic             ack_mc,
   input logic             ovf_pend,
   input logic             mc_pend,
   input logic             ovf_evt,
   input logic             mc_set,
   input logic             cap_fire,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] data_q,
   input logic             tgl_out,
   input logic             pwm_out,
   input logic             wr_en,
   input logic [CNT_W-1:0] wr_data
);
   a_r2_toggle_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tgl_out) |-> mc_pend);

   a_r3_pwm_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_out |-> (data_q != '0));

   a_r4_cap_loads_count: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire |=> (data_q == $past(cnt)));

   a_r5_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_pend);

   a_r6_ack_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ovf && !ovf_evt) |=> !ovf_pend);

   a_r6_ack_mc: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_mc && !mc_set) |=> !mc_pend);

   a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !cnt_clr && (mode_sel == mode_q)) |=> $stable(cnt));

   a_r8_cpu_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cap_fire) |=> (data_q == $past(wr_data)));

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (cnt == '0));

   a_r9_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clr && !ack_ovf) |=> (ovf_pend == $past(ovf_pend)));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 2'd3) && (mode_sel == 2'd3) && !cnt_clr) |=> $stable(cnt));
endmodule

bind multimode_timer mmt_checker #(.CNT_W(CNT_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .cnt_clr  (cnt_clr),
   .mode_sel (mode_sel),
   .mode_q   (mode_q),
   .ack_ovf  (ack_ovf),
   .ack_mc   (ack_mc),
   .ovf_pend (ovf_pend),
   .mc_pend  (mc_pend),
   .ovf_evt  (ovf_evt),
   .mc_set   (mc_set),
   .cap_fire (cap_fire),
   .cnt      (cnt),
   .data_q   (data_q),
   .tgl_out  (tgl_out),
   .pwm_out  (pwm_out),
   .wr_en    (wr_en),
   .wr_data  (wr_data)
);

// File: tb/multimode_timer_tb.sv
`timescale 1ns/1ps
module multimode_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [1:0] mode_sel = 2'd0;
   logic       cnt_clr = 1'b0;
   logic       cap_rise = 1'b1;
   logic       cap_pin = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic       ack_ovf = 1'b0;
   logic       ack_mc = 1'b0;
   logic       tgl_out, pwm_out, ovf_pend, mc_pend;
   logic [7:0] data_q;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   multimode_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
      .cnt_clr(cnt_clr), .cap_rise(cap_rise), .cap_pin(cap_pin),
      .wr_en(wr_en), .wr_data(wr_data), .ack_ovf(ack_ovf), .ack_mc(ack_mc),
      .tgl_out(tgl_out), .pwm_out(pwm_out), .data_q(data_q),
      .ovf_pend(ovf_pend), .mc_pend(mc_pend)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic nx();
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   // clear counter and both flags; clear blocks events in that cycle
   task automatic clr_all();
      cnt_clr = 1'b1; ack_ovf = 1'b1; ack_mc = 1'b1;
      nx();
      cnt_clr = 1'b0; ack_ovf = 1'b0; ack_mc = 1'b0;
   endtask

   task automatic write_ref(input logic [7:0] v);
      wr_en = 1'b1; wr_data = v;
      nx();
      wr_en = 1'b0;
   endtask

   // count edges until the toggle flips
   task automatic wait_toggle(output int edges);
      logic t0;
      t0 = tgl_out;
      edges = 0;
      while (tgl_out == t0 && edges < 600) begin
         nx();
         edges++;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int e;
      int hi;
      int bad;
      int ticks;
      int pwm_vals[10] = '{0, 1, 2, 3, 64, 127, 128, 200, 254, 255};

      nx(); nx();
      // R1 reset state
      chk(tgl_out == 0 && pwm_out == 0, "R1 outputs", tgl_out, 0);
      chk(data_q == 0, "R1 data", data_q, 0);
      chk(ovf_pend == 0 && mc_pend == 0, "R1 flags", {ovf_pend, mc_pend}, 0);
      rst_n = 1'b1;
      nx();
      chk(tgl_out == 0 && mc_pend == 0, "R1 after release", tgl_out, 0);

      // R2 interval period sweep
      tick_en = 1'b1;
      for (int d = 0; d <= 22; d++) begin
         int dv;
         dv = (d == 21) ? 100 : (d == 22) ? 255 : d;
         write_ref(8'(dv));
         clr_all();
         wait_toggle(e);
         chk(e == dv + 1, "R2 interval period", e, dv + 1);
         chk(mc_pend == 1, "R2 match flag", mc_pend, 1);
      end

      // R7 ticks every other cycle
      write_ref(8'd4);
      clr_all();
      begin
         logic t0;
         t0 = tgl_out; ticks = 0; e = 0;
         while (tgl_out == t0 && e < 100) begin
            tick_en = ~tick_en;
            if (tick_en) ticks++;
            nx();
            e++;
         end
      end
      chk(ticks == 5, "R7 gated ticks", ticks, 5);
      chk(e == 10, "R7 gated clocks", e, 10);
      tick_en = 1'b1;

      // R3 PWM duty sweep
      for (int k = 0; k < 10; k++) begin
         mode_sel = 2'd1; wr_en = 1'b1; wr_data = 8'(pwm_vals[k]); cnt_clr = 1'b1;
         nx();
         wr_en = 1'b0; cnt_clr = 1'b0;
         hi = 0; bad = 0;
         for (int i = 0; i < 256; i++) begin
            if (pwm_out) hi++;
            if (pwm_out != (i < pwm_vals[k])) bad++;
            nx();
         end
         chk(hi == pwm_vals[k], "R3 pwm high count", hi, pwm_vals[k]);
         chk(bad == 0, "R3 pwm shape", bad, 0);
         chk(pwm_out == (pwm_vals[k] > 0), "R3 pwm wrap", pwm_out, pwm_vals[k] > 0);
      end

      // R4 capture on rising edge with offset sweep
      mode_sel = 2'd2; cap_rise = 1'b1; cap_pin = 1'b0;
      nx(); nx(); nx();
      for (int j = 0; j <= 10; j++) begin
         clr_all();
         repeat (j) nx();
         cap_pin = 1'b1;
         nx(); nx();
         chk(mc_pend == 0, "R4 not early", mc_pend, 0);
         nx();
         chk(data_q == j + 2, "R4 captured count", data_q, j + 2);
         chk(mc_pend == 1, "R4 capture flag", mc_pend, 1);
         ack_mc = 1'b1; cap_pin = 1'b0;
         nx();
         ack_mc = 1'b0;
         repeat (4) nx();
         chk(mc_pend == 0 && data_q == j + 2, "R4 falling ignored", data_q, j + 2);
      end

      // R4 falling polarity
      cap_rise = 1'b0;
      clr_all();
      cap_pin = 1'b1;
      repeat (5) nx();
      chk(mc_pend == 0, "R4 rising ignored", mc_pend, 0);
      clr_all();
      repeat (5) nx();
      cap_pin = 1'b0;
      repeat (3) nx();
      chk(data_q == 7 && mc_pend == 1, "R4 falling capture", data_q, 7);

      // R8 capture beats CPU write, then plain write
      cap_rise = 1'b1;
      clr_all();
      repeat (3) nx();
      cap_pin = 1'b1;
      nx(); nx();
      wr_en = 1'b1; wr_data = 8'hA5;
      nx();
      wr_en = 1'b0;
      chk(data_q == 5, "R8 capture wins", data_q, 5);
      wr_en = 1'b1; wr_data = 8'h3C;
      nx();
      wr_en = 1'b0;
      chk(data_q == 8'h3C, "R8 write next clock", data_q, 8'h3C);
      cap_pin = 1'b0;
      repeat (4) nx();

      // R5 overflow in capture mode
      clr_all();
      repeat (255) nx();
      chk(ovf_pend == 0, "R5 no early overflow", ovf_pend, 0);
      nx();
      chk(ovf_pend == 1, "R5 overflow at wrap", ovf_pend, 1);

      // R6 set wins over ack, then ack clears
      repeat (255) nx();
      ack_ovf = 1'b1;
      nx();
      ack_ovf = 1'b0;
      chk(ovf_pend == 1, "R6 set beats ack", ovf_pend, 1);

      // R9 mode change clears the counter and keeps the flags
      write_ref(8'd6);
      mode_sel = 2'd0;
      nx();
      chk(ovf_pend == 1, "R9 flag kept on mode change", ovf_pend, 1);
      wait_toggle(e);
      chk(e == 7, "R9 counter cleared by mode change", e, 7);
      ack_ovf = 1'b1;
      nx();
      ack_ovf = 1'b0;
      chk(ovf_pend == 0, "R6 ack clears", ovf_pend, 0);

      // R10 idle mode
      clr_all();
      mode_sel = 2'd3;
      begin
         logic t0;
         t0 = tgl_out;
         repeat (300) nx();
         chk(tgl_out == t0, "R10 no toggle", tgl_out, t0);
      end
      chk(ovf_pend == 0 && mc_pend == 0, "R10 no events", {ovf_pend, mc_pend}, 0);
      chk(pwm_out == 0, "R3 pwm low outside pwm", pwm_out, 0);

      summary();
      $finish;
   end
endmodule